// File: doc/BRIEF.md
# Self-Arbitrating Half-Duplex SPI Endpoint

This block is one end of a point-to-point serial link between two identical nodes. Each node can be clock master or selected slave on a shared SCK/MOSI pair. Either node may start traffic at any time. A node that is slave and has a byte to send takes the bus through a handshake on two cross-wired select lines: it pulls the peer's select low, and the peer, once idle between messages, steps down and releases the requester's select high. The rising edge on that line is the acknowledge. The requester then takes over as master and shifts its byte.

On the local side the node has a byte transmit port with valid/ready and a message-end marker, and a receive port fed from a small internal FIFO. Data always flows from master to slave on MOSI. A transfer is eight bits, least significant bit first. SCK idles high and the slave samples on the falling (leading) edge. SCK is the system clock divided by a parameter. In slave role, SCK, MOSI and the select input pass through two-flop synchronizers before edge detection.

Top module: `spi_swap_node`

## Requirements
- R1: After reset, the node with START_MASTER=1 is master and holds `peer_sel_o` low. The other node is slave and holds `peer_sel_o` high. SCK idles high and both receive FIFOs are empty.
- R2: A master ignores a low level on `sel_i` until it has finished a message, that is, until it has shifted a byte that was accepted with `tx_last`=1.
- R3: A byte is sent on `mosi_o` least significant bit first, with eight SCK pulses. SCK idles high and each SCK period is CLK_DIV system clocks. The slave samples MOSI on the falling edge of SCK.
- R4: Each byte a slave receives goes into the receive FIFO and is read out in arrival order. A byte is presented while `rx_valid` is 1 and is removed by `rx_ready`.
- R5: A byte that completes while the receive FIFO already holds RX_DEPTH entries is dropped. The stored entries stay unchanged.
- R6: A slave with `tx_valid`=1 drives `peer_sel_o` low and raises `swap_o`, and holds `tx_ready` low. It becomes master only after it sees `sel_i` high, and then sends the pending byte.
- R7: An idle master that has finished a message and sees `sel_i` low becomes slave and drives `peer_sel_o` high.
- R8: Between the bytes of an unfinished message, the master ignores switch requests. The peer's byte goes out only after the last byte of the message.
- R9: If the master has a byte pending when the slave requests the bus, the master's byte is sent first. The slave's byte follows once that message ends.
- R10: A master never writes into its own receive FIFO. Traffic it sends does not come back as received data.
- R11: `role_o` is 1 in master role. `busy_o` is 1 while a byte is being shifted. `swap_o` is 1 during a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte is valid |
| tx_last | input | 1 | Byte ends a message |
| tx_ready | output | 1 | Byte accepted this cycle when valid |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Remove the presented byte |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | SCK output enable (master role) |
| sck_i | input | 1 | Serial clock seen on the line |
| mosi_o | output | 1 | Serial data driven in master role |
| mosi_oe | output | 1 | MOSI output enable (master role) |
| mosi_i | input | 1 | Serial data seen on the line |
| sel_i | input | 1 | Own select, active low, driven by the peer |
| peer_sel_o | output | 1 | Select line of the peer |
| role_o | output | 1 | 1 = master |
| busy_o | output | 1 | Byte transfer in progress |
| swap_o | output | 1 | Bus request in progress |

## Verification
The bench wires two nodes back to back. It rebuilds every byte from the MOSI line at the SCK falling edges. A node that shifted the bits in the wrong order, or changed data on the sampling edge, would put a different value on the line than the one queued.

It sends a three-byte message while the slave is asking for the bus. A master that yielded between bytes would let the slave's byte appear inside the message. It also raises both transmit requests in the same cycle. A node that let the requester win would put the slave's byte first.

It forces the master's select low before any message has ended. A node that honoured the request early would give up the master role.

It overfills the receive FIFO and then drains it. A FIFO that wrapped, or that kept the late bytes, would return them instead of the first RX_DEPTH bytes.

// File: rtl/spi_swap_pkg.sv
package spi_swap_pkg;

  typedef enum logic [1:0] {
    ST_SLAVE  = 2'd0,  // selected by peer, receiving
    ST_REQ    = 2'd1,  // asking the peer to step down
    ST_MIDLE  = 2'd2,  // master, waiting for a byte
    ST_MSHIFT = 2'd3   // master, shifting a byte
  } node_state_t;

endpackage

// File: rtl/spi_swap_sync.sv
module spi_swap_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/spi_swap_fifo.sv
module spi_swap_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         not_empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign head_data = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == CW'(DEPTH)) && $stable(wr_q));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/spi_swap_node.sv
module spi_swap_node
  import spi_swap_pkg::*;
#(
  parameter bit START_MASTER = 1'b0,
  parameter int CLK_DIV      = 8,
  parameter int DATA_W       = 8,
  parameter int RX_DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              sel_i,
  output logic              peer_sel_o,
  output logic              role_o,
  output logic              busy_o,
  output logic              swap_o
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(HALF + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam node_state_t RST_STATE = START_MASTER ? ST_MIDLE : ST_SLAVE;

  node_state_t       state_q, state_d;
  logic              armed_q, armed_d;
  logic              open_q, open_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              sck_q, sck_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] txsh_q, txsh_d;
  logic              last_q, last_d;
  logic [DATA_W-1:0] rxsh_q, rxsh_d;
  logic [BIT_W-1:0]  rxcnt_q, rxcnt_d;
  logic              sckprev_q;

  logic              sck_s, mosi_s, sel_s;
  logic              sck_fall, rx_on, push;
  logic [DATA_W-1:0] push_data;

  spi_swap_sync #(.W(3), .RST_VAL(3'b111)) pin_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_i, mosi_i, sel_i}),
    .q     ({sck_s, mosi_s, sel_s})
  );

  spi_swap_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) rx_fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (rx_ready),
    .head_data (rx_data),
    .not_empty (rx_valid)
  );

  assign sck_fall  = sckprev_q && !sck_s;
  assign rx_on     = (state_q == ST_SLAVE) || (state_q == ST_REQ);
  assign push_data = {mosi_s, rxsh_q[DATA_W-1:1]};

  // slave receive path
  always_comb begin
    rxsh_d  = rxsh_q;
    rxcnt_d = rxcnt_q;
    push    = 1'b0;
    if (!rx_on || sel_s) begin
      rxcnt_d = '0;
    end else if (sck_fall) begin
      rxsh_d  = push_data;
      rxcnt_d = rxcnt_q + 1'b1;
      if (rxcnt_q == BIT_W'(DATA_W - 1)) begin
        push    = 1'b1;
        rxcnt_d = '0;
      end
    end
  end

  // role control and master shift path
  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    open_d  = open_q;
    div_d   = div_q;
    sck_d   = sck_q;
    bit_d   = bit_q;
    txsh_d  = txsh_q;
    last_d  = last_q;
    unique case (state_q)
      ST_SLAVE: begin
        if (tx_valid) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (sel_s) begin
          state_d = ST_MIDLE;
          armed_d = 1'b0;
          open_d  = 1'b0;
        end
      end
      ST_MIDLE: begin
        if (tx_valid) begin
          txsh_d  = tx_data;
          last_d  = tx_last;
          div_d   = '0;
          bit_d   = '0;
          sck_d   = 1'b1;
          state_d = ST_MSHIFT;
        end else if (armed_q && !open_q && !sel_s) begin
          state_d = ST_SLAVE;
        end
      end
      ST_MSHIFT: begin
        if (div_q == DIV_W'(HALF - 1)) begin
          div_d = '0;
          sck_d = !sck_q;
          if (!sck_q) begin
            if (bit_q == BIT_W'(DATA_W - 1)) begin
              state_d = ST_MIDLE;
              open_d  = !last_q;
              if (last_q) armed_d = 1'b1;
            end else begin
              bit_d  = bit_q + 1'b1;
              txsh_d = {1'b1, txsh_q[DATA_W-1:1]};
            end
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: state_d = RST_STATE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RST_STATE;
      armed_q   <= 1'b0;
      open_q    <= 1'b0;
      div_q     <= '0;
      sck_q     <= 1'b1;
      bit_q     <= '0;
      txsh_q    <= '1;
      last_q    <= 1'b0;
      rxsh_q    <= '0;
      rxcnt_q   <= '0;
      sckprev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      armed_q   <= armed_d;
      open_q    <= open_d;
      div_q     <= div_d;
      sck_q     <= sck_d;
      bit_q     <= bit_d;
      txsh_q    <= txsh_d;
      last_q    <= last_d;
      rxsh_q    <= rxsh_d;
      rxcnt_q   <= rxcnt_d;
      sckprev_q <= sck_s;
    end
  end

  assign role_o     = (state_q == ST_MIDLE) || (state_q == ST_MSHIFT);
  assign tx_ready   = (state_q == ST_MIDLE);
  assign swap_o     = (state_q == ST_REQ);
  assign busy_o     = (state_q == ST_MSHIFT) || (rx_on && rxcnt_q != '0);
  assign peer_sel_o = (state_q == ST_SLAVE);
  assign sck_o      = sck_q;
  assign sck_oe     = role_o;
  assign mosi_o     = txsh_q[0];
  assign mosi_oe    = role_o;

  // R6
  swap_blocks_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> !tx_ready && !peer_sel_o);

  // R6
  take_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(role_o) |-> $past(sel_s) && $past(swap_o));

  // R7 R8 R9
  yield_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(role_o) |-> $past(armed_q && !open_q && !tx_valid && !sel_s));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (role_o && state_q != ST_MSHIFT) |-> sck_o);

  // R10
  no_self_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    role_o |-> !push);

endmodule

// File: tb/spi_swap_node_tb.sv
module spi_swap_node_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic       clk, rst_n;
  logic [7:0] tx_data  [2];
  logic       tx_valid [2];
  logic       tx_last  [2];
  logic       tx_ready [2];
  logic [7:0] rx_data  [2];
  logic       rx_valid [2];
  logic       rx_ready [2];
  logic       sck_o [2], sck_oe [2], mosi_o [2], mosi_oe [2];
  logic       peer_sel [2], role [2], busy [2], swap [2];
  logic       sel_ovr;
  logic       sck_line, mosi_line, sel_a, sel_b;

  int n_chk, n_err;
  logic [7:0] mon_log [32];
  logic [7:0] mon_sh;
  int mon_bits, mon_n;
  int swap_seen_b, swap_bad;

  assign sck_line  = sck_oe[0]  ? sck_o[0]  : (sck_oe[1]  ? sck_o[1]  : 1'b1);
  assign mosi_line = mosi_oe[0] ? mosi_o[0] : (mosi_oe[1] ? mosi_o[1] : 1'b1);
  assign sel_a     = sel_ovr ? 1'b0 : peer_sel[1];
  assign sel_b     = peer_sel[0];

  spi_swap_node #(.START_MASTER(1'b1), .CLK_DIV(8), .RX_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_data(tx_data[0]), .tx_valid(tx_valid[0]), .tx_last(tx_last[0]), .tx_ready(tx_ready[0]),
    .rx_data(rx_data[0]), .rx_valid(rx_valid[0]), .rx_ready(rx_ready[0]),
    .sck_o(sck_o[0]), .sck_oe(sck_oe[0]), .sck_i(sck_line),
    .mosi_o(mosi_o[0]), .mosi_oe(mosi_oe[0]), .mosi_i(mosi_line),
    .sel_i(sel_a), .peer_sel_o(peer_sel[0]),
    .role_o(role[0]), .busy_o(busy[0]), .swap_o(swap[0]));

  spi_swap_node #(.START_MASTER(1'b0), .CLK_DIV(8), .RX_DEPTH(DEPTH)) peer_i (
    .clk(clk), .rst_n(rst_n),
    .tx_data(tx_data[1]), .tx_valid(tx_valid[1]), .tx_last(tx_last[1]), .tx_ready(tx_ready[1]),
    .rx_data(rx_data[1]), .rx_valid(rx_valid[1]), .rx_ready(rx_ready[1]),
    .sck_o(sck_o[1]), .sck_oe(sck_oe[1]), .sck_i(sck_line),
    .mosi_o(mosi_o[1]), .mosi_oe(mosi_oe[1]), .mosi_i(mosi_line),
    .sel_i(sel_b), .peer_sel_o(peer_sel[1]),
    .role_o(role[1]), .busy_o(busy[1]), .swap_o(swap[1]));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = !clk;
  end

  // line monitor: rebuild bytes LSB first at SCK falling edges
  initial begin
    mon_bits = 0; mon_n = 0; mon_sh = '0;
    forever begin
      @(negedge sck_line);
      mon_sh = {mosi_line, mon_sh[7:1]};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_log[mon_n % 32] = mon_sh;
        mon_n++;
        mon_bits = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (swap[1]) swap_seen_b++;
    if (swap[1] && tx_ready[1]) swap_bad++;
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(int n, logic [7:0] d, logic last);
    @(negedge clk);
    tx_data[n] = d; tx_last[n] = last; tx_valid[n] = 1'b1;
    while (!tx_ready[n]) @(negedge clk);
    @(negedge clk);
    tx_valid[n] = 1'b0;
  endtask

  task automatic wait_line(int target);
    for (int i = 0; i < 4000 && mon_n < target; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic pop(int n, output logic [7:0] d, output logic ok);
    ok = 1'b0; d = 'x;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rx_valid[n]) begin ok = 1'b1; d = rx_data[n]; break; end
    end
    if (ok) begin
      rx_ready[n] = 1'b1;
      @(negedge clk);
      rx_ready[n] = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 role A", role[0], 1);
    chk("R1 role B", role[1], 0);
    chk("R1 peer_sel A", peer_sel[0], 0);
    chk("R1 peer_sel B", peer_sel[1], 1);
    chk("R1 sck idle", sck_line, 1);
    chk("R1 rx empty", {rx_valid[0], rx_valid[1]}, 0);
    chk("R11 swap idle", {swap[0], swap[1]}, 0);
  endtask

  task automatic t_early_ignore();
    @(negedge clk); sel_ovr = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 master kept", role[0], 1);
    sel_ovr = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_single();
    logic [7:0] d; logic ok; int base;
    base = mon_n;
    send(0, 8'h2D, 1'b1);
    chk("R11 busy during shift", busy[0], 1);
    wait_line(base + 1);
    chk("R3 line byte LSB first", mon_log[base % 32], 8'h2D);
    pop(1, d, ok);
    chk("R4 slave got byte", {ok, d}, {1'b1, 8'h2D});
    chk("R10 master rx empty", rx_valid[0], 0);
  endtask

  task automatic t_overfill();
    logic [7:0] d; logic ok; int base;
    base = mon_n;
    for (int i = 0; i < DEPTH + 2; i++) send(0, 8'h40 + 8'(i), (i == DEPTH + 1));
    wait_line(base + DEPTH + 2);
    for (int i = 0; i < DEPTH; i++) begin
      pop(1, d, ok);
      chk("R5 kept in order", {ok, d}, {1'b1, 8'h40 + 8'(i)});
    end
    repeat (3) @(negedge clk);
    chk("R5 late bytes dropped", rx_valid[1], 0);
  endtask

  task automatic t_hold_message();
    logic [7:0] d; logic ok; int base;
    base = mon_n;
    fork
      begin send(0, 8'h11, 1'b0); send(0, 8'h22, 1'b0); send(0, 8'h33, 1'b1); end
      begin repeat (5) @(negedge clk); send(1, 8'hC3, 1'b1); end
    join
    wait_line(base + 4);
    chk("R8 msg byte0", mon_log[base % 32], 8'h11);
    chk("R8 msg byte1", mon_log[(base + 1) % 32], 8'h22);
    chk("R8 msg byte2", mon_log[(base + 2) % 32], 8'h33);
    chk("R6 peer byte after msg", mon_log[(base + 3) % 32], 8'hC3);
    chk("R6 swap seen", swap_seen_b > 0, 1);
    chk("R6 tx_ready low in swap", swap_bad, 0);
    chk("R7 A now slave", role[0], 0);
    chk("R7 A released peer sel", peer_sel[0], 1);
    chk("R6 B now master", role[1], 1);
    for (int i = 0; i < 3; i++) begin
      pop(1, d, ok);
      chk("R4 B msg order", {ok, d}, {1'b1, 8'h11 * 8'(i + 1)});
    end
    repeat (3) @(negedge clk);
    chk("R10 B did not keep own byte", rx_valid[1], 0);
    pop(0, d, ok);
    chk("R4 A got peer byte", {ok, d}, {1'b1, 8'hC3});
  endtask

  task automatic t_tie();
    logic [7:0] d; logic ok; int base;
    base = mon_n;
    fork
      send(0, 8'h5A, 1'b1);
      send(1, 8'hA5, 1'b1);
    join
    wait_line(base + 2);
    chk("R9 master byte first", mon_log[base % 32], 8'hA5);
    chk("R9 requester byte second", mon_log[(base + 1) % 32], 8'h5A);
    chk("R11 A master again", role[0], 1);
    pop(0, d, ok);
    chk("R9 A received", {ok, d}, {1'b1, 8'hA5});
    pop(1, d, ok);
    chk("R9 B received", {ok, d}, {1'b1, 8'h5A});
  endtask

  initial begin
    n_chk = 0; n_err = 0; swap_seen_b = 0; swap_bad = 0;
    sel_ovr = 1'b0;
    for (int n = 0; n < 2; n++) begin
      tx_data[n] = '0; tx_valid[n] = 1'b0; tx_last[n] = 1'b0; rx_ready[n] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_early_ignore();
    t_single();
    t_overfill();
    t_hold_message();
    t_tie();
    repeat (10) @(negedge clk);
    summary();
  end

endmodule